// File: doc/BRIEF.md
# Constant on-time buck gate sequencer

This block is the digital core of a hysteretic synchronous step-down converter. It has no oscillator. A high-side pulse of programmable length starts when three things are true at once: a latched turn-on request from the feedback comparator, a minimum off-time that has run out since the last pulse, and a valley current-limit flag that is clear. Between the two switches the block waits on adaptive dead-time handshakes. Before it enables the low side it waits for a switch-node-low flag. Before it enables the high side it waits for a low-side-gate-low flag. If a flag never arrives, a timeout lets the sequence move on.

All inputs are comparator results that are already digitized and synchronous to a fast system clock. The on-time and off-time are counts of that clock. A mode input chooses between two behaviours. In pulse-skipping mode the low side turns off at the inductor zero crossing. In forced-continuous mode the low side stays on until the next pulse, so the converter can sink current. When the block is disabled or a fault is latched, it holds the high side off and the low side on.

Top module: `cot_gate_seq`

## Requirements
- R1: A new high-side pulse is launched only when three conditions hold together in the same cycle: the turn-on request is latched, the off-time count has reached `TOFF_MIN`, and `ilim_hit` is low. A request that arrives while the low side is parked off (pulse-skipping idle) also launches a pulse.
- R2: A single-cycle `fb_low` is remembered and yields exactly one pulse. The request clears on the last on-time cycle, so no further pulse follows while `fb_low` stays low.
- R3: `hs_on` stays high for exactly `ton_cmd + TON_PAD` clock cycles when `ton_cmd >= TON_FLOOR`.
- R4: When `ton_cmd < TON_FLOOR`, the pulse lasts `TON_FLOOR + TON_PAD` cycles.
- R5: Between two high-side pulses, `hs_on` stays low for at least `TOFF_MIN` cycles.
- R6: After `hs_on` falls, `ls_on` rises only after `sw_low` has been seen high. If `sw_low` never rises, `ls_on` rises after exactly `DT_TIMEOUT + 1` cycles with both gates off.
- R7: After `ls_on` falls, `hs_on` rises only after `lg_low` has been seen high. If `lg_low` never rises, `hs_on` rises after exactly `DT_TIMEOUT + 1` cycles with both gates off.
- R8: With `fccm` = 0, a `zero_cross` while the low side is on turns `ls_on` off, and it stays off until the next pulse. With `fccm` = 1, `zero_cross` is ignored and `ls_on` stays high.
- R9: During reset, and in the cycle after `en` goes low or `fault` goes high, `hs_on` = 0 and `ls_on` = 1. No pulse starts while that condition lasts, and the off-time restarts when it ends.
- R10: While `ilim_hit` is high, no new pulse starts, even when a request is pending.
- R11: `hs_on` and `ls_on` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable |
| fccm | input | 1 | 1 = forced-continuous, 0 = pulse-skipping |
| fault | input | 1 | Latched protection fault from outside |
| ton_cmd | input | CNT_W | Requested on-time in clock cycles |
| fb_low | input | 1 | Feedback below reference |
| ilim_hit | input | 1 | Valley current above limit |
| zero_cross | input | 1 | Inductor current reached zero |
| sw_low | input | 1 | Switch node below low threshold |
| lg_low | input | 1 | Low-side gate below threshold |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |

## Verification
The dead-time timeouts are the hardest paths to reach. They only happen when a power-stage flag fails to respond, and a well-behaved plant always answers. The bench emulates the plant: the handshake flags follow the gate enables after two cycles. Each flag can also be pinned low on its own for a stretch of switching cycles. That forces each handshake through its timeout, and the gap with both gates off is then measured. The per-cycle model also has to follow a `ton_cmd` that changes in the middle of a run, and a fault that arrives during an on-time pulse.

// File: rtl/cot_gate_seq.sv
module cot_gate_seq #(
  parameter int CNT_W      = 10,
  parameter int TOFF_MIN   = 58,
  parameter int TON_FLOOR  = 15,
  parameter int TON_PAD    = 7,
  parameter int DT_TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fccm,
  input  logic             fault,
  input  logic [CNT_W-1:0] ton_cmd,
  input  logic             fb_low,
  input  logic             ilim_hit,
  input  logic             zero_cross,
  input  logic             sw_low,
  input  logic             lg_low,
  output logic             hs_on,
  output logic             ls_on
);
  localparam int OW = $clog2(TOFF_MIN + 1);
  localparam int DW = $clog2(DT_TIMEOUT + 1);
  localparam logic [OW-1:0]  OFF_MAX = OW'(TOFF_MIN);
  localparam logic [DW-1:0]  DT_MAX  = DW'(DT_TIMEOUT);
  localparam logic [CNT_W:0] FLOOR_V = (CNT_W+1)'(TON_FLOOR);
  localparam logic [CNT_W:0] PAD_V   = (CNT_W+1)'(TON_PAD);

  typedef enum logic [2:0] {S_HOLD, S_LS, S_IDLE, S_DT_LH, S_HS, S_DT_HL} seq_t;

  seq_t           state_q, state_d;
  logic           req_q;
  logic [OW-1:0]  off_q;
  logic [DW-1:0]  dt_q;
  logic [CNT_W:0] ton_q;

  logic stop, off_ok, start, ton_end;
  logic [CNT_W:0] ton_len;

  assign stop    = !en || fault;
  assign off_ok  = (off_q == OFF_MAX);
  assign start   = req_q && off_ok && !ilim_hit;
  assign ton_end = (state_q == S_HS) && (ton_q == (CNT_W+1)'(1));
  assign ton_len = (({1'b0, ton_cmd} < FLOOR_V) ? FLOOR_V : {1'b0, ton_cmd}) + PAD_V;

  always_comb begin
    state_d = state_q;
    if (stop) state_d = S_HOLD;
    else begin
      unique case (state_q)
        S_HOLD:  state_d = S_LS;
        S_LS:    if (start) state_d = S_DT_LH;
                 else if (!fccm && zero_cross) state_d = S_IDLE;
        S_IDLE:  if (start) state_d = S_DT_LH;
        S_DT_LH: if (lg_low || dt_q == DT_MAX) state_d = S_HS;
        S_HS:    if (ton_end) state_d = S_DT_HL;
        S_DT_HL: if (sw_low || dt_q == DT_MAX) state_d = S_LS;
        default: state_d = S_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_HOLD;
      req_q   <= 1'b0;
      off_q   <= '0;
      dt_q    <= '0;
      ton_q   <= '0;
    end else begin
      state_q <= state_d;
      req_q   <= stop ? 1'b0 : ((req_q || fb_low) && !ton_end);
      if (stop || state_q == S_HS) off_q <= '0;
      else if (!off_ok)            off_q <= off_q + 1'b1;
      if ((state_q == S_DT_LH || state_q == S_DT_HL) && state_d == state_q) dt_q <= dt_q + 1'b1;
      else dt_q <= '0;
      if (state_q == S_DT_LH && state_d == S_HS) ton_q <= ton_len;
      else if (state_q == S_HS)                  ton_q <= ton_q - 1'b1;
    end
  end

  assign hs_on = (state_q == S_HS);
  assign ls_on = (state_q == S_LS) || (state_q == S_HOLD);

  p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n) !(hs_on && ls_on));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || fault) |=> (!hs_on && ls_on));
  p_minoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DT_LH) |-> (off_q == OFF_MAX));
  p_ilim_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_LS || state_q == S_IDLE) && ilim_hit) |=> (state_q != S_DT_LH));
  p_lg_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DT_LH && !lg_low && dt_q != DT_MAX) |=> !hs_on);
  p_sw_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DT_HL && !sw_low && dt_q != DT_MAX && en && !fault) |=> !ls_on);
  p_skip_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_LS && !fccm && zero_cross && !start && !stop) |=> !ls_on);
endmodule

// File: tb/cot_gate_seq_bench.sv
module cot_gate_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 10, TOFF_MIN = 58, TON_FLOOR = 15, TON_PAD = 7, DT_TIMEOUT = 16;

  logic clk = 0, rst_n = 0, en = 0, fccm = 1, fault = 0;
  logic [CNT_W-1:0] ton_cmd = 30;
  logic fb_low = 0, ilim_hit = 0, zero_cross = 0, sw_low = 1, lg_low = 0;
  logic hs_on, ls_on;

  cot_gate_seq #(.CNT_W(CNT_W), .TOFF_MIN(TOFF_MIN), .TON_FLOOR(TON_FLOOR),
                 .TON_PAD(TON_PAD), .DT_TIMEOUT(DT_TIMEOUT)) u_cot_gate_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .fccm(fccm), .fault(fault), .ton_cmd(ton_cmd),
    .fb_low(fb_low), .ilim_hit(ilim_hit), .zero_cross(zero_cross), .sw_low(sw_low),
    .lg_low(lg_low), .hs_on(hs_on), .ls_on(ls_on));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural plant and reference model; modes: 0 hold,1 low,2 park,3 gap-up,4 high,5 gap-down
  int m_mode = 0, m_off = 0, m_ton = 0, m_dt = 0, nm, len;
  bit m_req = 0, tend, go;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_off = 0; m_ton = 0; m_dt = 0; m_req = 0;
    end else begin
      tend = (m_mode == 4 && m_ton == 1);
      go = m_req && (m_off == TOFF_MIN) && !ilim_hit;
      len = ((int'(ton_cmd) < TON_FLOOR) ? TON_FLOOR : int'(ton_cmd)) + TON_PAD;
      nm = m_mode;
      if (!en || fault) nm = 0;
      else case (m_mode)
        0: nm = 1;
        1: if (go) nm = 3; else if (!fccm && zero_cross) nm = 2;
        2: if (go) nm = 3;
        3: if (lg_low || m_dt == DT_TIMEOUT) nm = 4;
        4: if (tend) nm = 5;
        5: if (sw_low || m_dt == DT_TIMEOUT) nm = 1;
        default: nm = 0;
      endcase
      if (m_mode == 3 && nm == 4) m_ton = len; else if (m_mode == 4) m_ton = m_ton - 1;
      if ((m_mode == 3 || m_mode == 5) && nm == m_mode) m_dt++; else m_dt = 0;
      if (!en || fault || m_mode == 4) m_off = 0; else if (m_off < TOFF_MIN) m_off++;
      m_req = (!en || fault) ? 1'b0 : ((m_req || fb_low) && !tend);
      m_mode = nm;
    end
  end

  bit sw_stuck = 0, lg_stuck = 0, hs_d1 = 0, hs_d2 = 0, ls_d1 = 1, ls_d2 = 1, prev_hs = 0, prev_ls = 1, seen = 0;
  int run = 0, last_w = 0, pulses = 0, lo_run = 0, both_run = 0, gap_hs = 0, gap_ls = 0;
  string tag;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      tag = (m_mode == 4) ? "R3" : (m_mode == 5) ? "R6" : (m_mode == 3) ? "R7" :
            (m_mode == 2) ? "R8" : (m_mode == 0) ? "R9" : "R1";
      chk(hs_on == (m_mode == 4) && ls_on == (m_mode <= 1), tag,
          {hs_on, ls_on}, {(m_mode == 4), (m_mode <= 1)});
      chk(!(hs_on && ls_on), "R11", {hs_on, ls_on}, 0);
    end
    if (hs_on && !prev_hs) begin
      if (seen) chk(lo_run >= TOFF_MIN, "R5", lo_run, TOFF_MIN);
      seen = 1; lo_run = 0; gap_hs = both_run;
    end
    if (ls_on && !prev_ls) gap_ls = both_run;
    if (!hs_on && !ls_on) both_run++; else both_run = 0;
    if (hs_on) run++;
    else begin
      lo_run++;
      if (run > 0) begin last_w = run; pulses++; run = 0; end
    end
    prev_hs = hs_on; prev_ls = ls_on;
    hs_d2 = hs_d1; hs_d1 = hs_on; ls_d2 = ls_d1; ls_d1 = ls_on;
    sw_low = sw_stuck ? 1'b0 : !hs_d2;
    lg_low = lg_stuck ? 1'b0 : !ls_d2;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  always @(posedge clk) if (cyc > 150000 && !done) begin
    done = 1; checks++; failures++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int p0;
  initial begin
    cycles(3);
    chk(!hs_on && ls_on, "R9", {hs_on, ls_on}, 1);
    rst_n = 1; en = 1; fb_low = 1; ton_cmd = 30;
    cycles(400);
    chk(last_w == 30 + TON_PAD, "R3", last_w, 30 + TON_PAD);
    chk(pulses >= 2, "R3", pulses, 2);
    ton_cmd = 3;
    cycles(300);
    chk(last_w == TON_FLOOR + TON_PAD, "R4", last_w, TON_FLOOR + TON_PAD);
    ilim_hit = 1;
    cycles(100);
    p0 = pulses;
    cycles(200);
    chk(pulses == p0, "R10", pulses, p0);
    ilim_hit = 0;
    cycles(150);
    chk(pulses > p0, "R1", pulses, p0 + 1);
    fb_low = 0;
    cycles(200);
    p0 = pulses;
    fb_low = 1; cycles(1); fb_low = 0;
    cycles(150);
    chk(pulses == p0 + 1, "R2", pulses, p0 + 1);
    cycles(200);
    chk(pulses == p0 + 1, "R2", pulses, p0 + 1);
    zero_cross = 1; cycles(1); zero_cross = 0;
    cycles(3);
    chk(ls_on == 1, "R8", ls_on, 1);
    fccm = 0;
    zero_cross = 1; cycles(1); zero_cross = 0;
    cycles(3);
    chk(ls_on == 0 && hs_on == 0, "R8", {hs_on, ls_on}, 0);
    p0 = pulses;
    fb_low = 1; cycles(1); fb_low = 0;
    cycles(150);
    chk(pulses == p0 + 1, "R1", pulses, p0 + 1);
    fccm = 1; sw_stuck = 1; fb_low = 1; ton_cmd = 20;
    cycles(300);
    chk(gap_ls == DT_TIMEOUT + 1, "R6", gap_ls, DT_TIMEOUT + 1);
    sw_stuck = 0;
    cycles(200);
    chk(gap_ls == 2, "R6", gap_ls, 2);
    lg_stuck = 1;
    cycles(300);
    chk(gap_hs == DT_TIMEOUT + 1, "R7", gap_hs, DT_TIMEOUT + 1);
    lg_stuck = 0;
    cycles(300);
    chk(gap_hs == 2, "R7", gap_hs, 2);
    for (int i = 0; i < 500 && !hs_on; i++) cycles(1);
    fault = 1;
    cycles(1);
    chk(!hs_on && ls_on, "R9", {hs_on, ls_on}, 1);
    p0 = pulses;
    cycles(100);
    chk(pulses == p0 && ls_on, "R9", pulses, p0);
    fault = 0;
    cycles(300);
    chk(pulses > p0, "R9", pulses, p0 + 1);
    en = 0;
    cycles(2);
    chk(!hs_on && ls_on, "R9", {hs_on, ls_on}, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule